// File: doc/BRIEF.md
# Receive Character Buffer with Threshold Flow Control

This block sits behind a serial character receiver. Each complete character arrives as a one-cycle strobe with an eight-bit value and two error tags, one for framing and one for parity. The block stores the value and its tags together in a sixteen-entry first-in first-out buffer. A processor drains the buffer through a read strobe. The value and tags come out of a read register. Reading an empty buffer leaves that register unchanged. A character that finds no room is dropped, and a sticky overrun flag records the loss.

To pace the far-end transmitter, the block drives an active-low ready-to-send output. With flow control enabled, the output goes high (stop) once free space falls to a chosen reserve of 0, 2, 4 or 8 entries. A transmitter that needs a few characters to react can still land them in the reserve. The output drops low (go) again only when reads raise free space to two entries above the reserve. This one entry of hysteresis keeps the output from toggling on a single read and write pair. With flow control disabled, the output stays low.

Top module: `rx_flow_fifo`

## Requirements
- R1: After reset: fill_level is 0, fifo_empty is 1, fifo_full is 0, rts_n is 0, ovr_flag is 0, and rd_data, rd_ferr and rd_perr are 0.
- R2: Characters come out in arrival order, each with its own framing and parity tags. rd_data, rd_ferr and rd_perr show the entry read at a clock edge from just after that edge.
- R3: fill_level counts the stored entries, from 0 to 16. fifo_empty marks level 0 and fifo_full marks level 16. A write and a read in the same cycle on a non-empty buffer leave the level unchanged.
- R4: A read while the buffer is empty changes neither rd_data, rd_ferr, rd_perr nor fill_level.
- R5: A write while the buffer is full and no read is made in the same cycle is dropped, and ovr_flag goes to 1 at that edge. The flag stays at 1 until a cycle with ovr_clear high and no new drop. A write to a full buffer with a read in the same cycle is accepted.
- R6: While fc_enable is 0, rts_n is 0 after every clock edge, whatever the level.
- R7: While fc_enable is 1, rts_n is 1 after any edge that leaves free space (16 minus fill_level) at or below the reserve. The reserve is selected by fc_thresh: 00 gives 0, 01 gives 2, 10 gives 4 and 11 gives 8. rts_n changes at the same edge as fill_level.
- R8: While fc_enable is 1, rts_n is 0 after any edge that leaves free space at or above the reserve plus 2. Between those two points it keeps its previous value.
- R9: Characters arriving while rts_n is 1 are still stored as long as the buffer is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_valid | input | 1 | One-cycle strobe for a received character |
| chr_data | input | 8 | Received character value |
| chr_ferr | input | 1 | Framing error tag of the character |
| chr_perr | input | 1 | Parity error tag of the character |
| rd_en | input | 1 | Processor read strobe |
| rd_data | output | 8 | Last character read |
| rd_ferr | output | 1 | Framing tag of the last character read |
| rd_perr | output | 1 | Parity tag of the last character read |
| fc_enable | input | 1 | Enables ready-to-send flow control |
| fc_thresh | input | 2 | Reserve select: 00=0, 01=2, 10=4, 11=8 free entries |
| ovr_clear | input | 1 | Clears the overrun flag |
| rts_n | output | 1 | Ready-to-send, low means send |
| fifo_empty | output | 1 | Buffer holds no entry |
| fifo_full | output | 1 | Buffer holds 16 entries |
| fill_level | output | 5 | Number of stored entries |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
All results of a strobe seen at a rising edge are due at that same edge. These are the read register, the level and both flags, the overrun flag and rts_n. None of them takes an extra cycle. The bench's monitor therefore samples the inputs at each rising edge. It updates its expected level, queue, overrun and ready-to-send state from them. It then compares every output 2 ns later, after the edge but well before the next falling edge, where the driver changes inputs. A read on an empty buffer is compared against the value held from the last real read.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

   typedef enum logic [1:0] {
      RSV_NONE  = 2'b00,
      RSV_TWO   = 2'b01,
      RSV_FOUR  = 2'b10,
      RSV_EIGHT = 2'b11
   } reserve_sel_e;

   typedef struct packed {
      logic ferr;
      logic perr;
   } err_tag_t;

   localparam int unsigned TAG_W = $bits(err_tag_t);

   // Free entries kept in reserve for each select code.
   function automatic int unsigned reserve_entries(input logic [1:0] sel);
      case (sel)
         RSV_TWO:   return 2;
         RSV_FOUR:  return 4;
         RSV_EIGHT: return 8;
         default:   return 0;
      endcase
   endfunction

endpackage

// File: rtl/rxfc_store.sv
module rxfc_store
   import rxfc_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = PTR_W + 1,
   localparam int unsigned ENT_W = DATA_W + TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  err_tag_t          wr_tag,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output err_tag_t          rd_tag,
   output logic [CNT_W-1:0]  level,
   output logic [CNT_W-1:0]  level_nxt,
   output logic              empty,
   output logic              full,
   output logic              drop
);

   logic [PTR_W-1:0] wptr_q, rptr_q;
   logic [CNT_W-1:0] level_q;
   logic             rd_fire, wr_acc;
   logic [ENT_W-1:0] ent_bus [DEPTH];
   logic [ENT_W-1:0] rd_q;

   assign empty   = (level_q == '0);
   assign full    = (level_q == CNT_W'(DEPTH));
   assign rd_fire = rd_req && !empty;
   // A read in the same cycle frees the slot a full buffer would lack.
   assign wr_acc  = wr_req && (!full || rd_fire);
   assign drop    = wr_req && !wr_acc;

   always_comb begin
      level_nxt = level_q;
      case ({wr_acc, rd_fire})
         2'b10:   level_nxt = level_q + CNT_W'(1);
         2'b01:   level_nxt = level_q - CNT_W'(1);
         default: level_nxt = level_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         level_q <= '0;
      end else begin
         level_q <= level_nxt;
         if (wr_acc)  wptr_q <= wptr_q + PTR_W'(1);
         if (rd_fire) rptr_q <= rptr_q + PTR_W'(1);
      end
   end

   // One storage register per entry; each loads only when addressed.
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      logic [ENT_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (wr_acc && (wptr_q == PTR_W'(gi)))
            slot_q <= {wr_tag, wr_data};
      end
      assign ent_bus[gi] = slot_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rd_q <= '0;
      else if (rd_fire) rd_q <= ent_bus[rptr_q];
   end

   assign rd_data = rd_q[DATA_W-1:0];
   assign rd_tag  = err_tag_t'(rd_q[ENT_W-1:DATA_W]);
   assign level   = level_q;

endmodule

// File: rtl/rxfc_rts_ctrl.sv
module rxfc_rts_ctrl
   import rxfc_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned HYST  = 1,
   localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [1:0]       sel,
   input  logic [CNT_W-1:0] level_nxt,
   output logic             rts_n
);

   if (DEPTH < reserve_entries(RSV_EIGHT) + HYST + 1) begin : g_bad_depth
      $error("rxfc_rts_ctrl: DEPTH too small for largest reserve plus hysteresis");
   end

   logic [31:0] free_nxt, stop_at, go_at;

   assign free_nxt = 32'(DEPTH) - 32'(level_nxt);
   assign stop_at  = 32'(reserve_entries(sel));
   assign go_at    = stop_at + 32'(HYST) + 32'd1;

   always_ff @(posedge clk) begin
      if (!rst_n)                 rts_n <= 1'b0;
      else if (!enable)           rts_n <= 1'b0;
      else if (free_nxt <= stop_at) rts_n <= 1'b1;
      else if (free_nxt >= go_at)   rts_n <= 1'b0;
   end

endmodule

// File: rtl/rxfc_ovr.sv
module rxfc_ovr (
   input  logic clk,
   input  logic rst_n,
   input  logic drop,
   input  logic clear,
   output logic flag
);

   always_ff @(posedge clk) begin
      if (!rst_n)     flag <= 1'b0;
      else if (drop)  flag <= 1'b1;
      else if (clear) flag <= 1'b0;
   end

endmodule

// File: rtl/rx_flow_fifo.sv
module rx_flow_fifo
   import rxfc_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned HYST   = 1,
   localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chr_valid,
   input  logic [DATA_W-1:0] chr_data,
   input  logic              chr_ferr,
   input  logic              chr_perr,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_ferr,
   output logic              rd_perr,
   input  logic              fc_enable,
   input  logic [1:0]        fc_thresh,
   input  logic              ovr_clear,
   output logic              rts_n,
   output logic              fifo_empty,
   output logic              fifo_full,
   output logic [CNT_W-1:0]  fill_level,
   output logic              ovr_flag
);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_pow2
      $error("rx_flow_fifo: DEPTH must be a power of two");
   end
   if (DATA_W == 0) begin : g_bad_width
      $error("rx_flow_fifo: DATA_W must be non-zero");
   end

   err_tag_t         in_tag, out_tag;
   logic [CNT_W-1:0] level_nxt;
   logic             drop;

   assign in_tag = '{ferr: chr_ferr, perr: chr_perr};

   rxfc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (chr_valid),
      .wr_data   (chr_data),
      .wr_tag    (in_tag),
      .rd_req    (rd_en),
      .rd_data   (rd_data),
      .rd_tag    (out_tag),
      .level     (fill_level),
      .level_nxt (level_nxt),
      .empty     (fifo_empty),
      .full      (fifo_full),
      .drop      (drop)
   );

   rxfc_rts_ctrl #(.DEPTH(DEPTH), .HYST(HYST)) u_rts (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (fc_enable),
      .sel       (fc_thresh),
      .level_nxt (level_nxt),
      .rts_n     (rts_n)
   );

   rxfc_ovr u_ovr (
      .clk   (clk),
      .rst_n (rst_n),
      .drop  (drop),
      .clear (ovr_clear),
      .flag  (ovr_flag)
   );

   assign rd_ferr = out_tag.ferr;
   assign rd_perr = out_tag.perr;

endmodule

// File: rtl/rx_flow_fifo_chk.sv
module rx_flow_fifo_chk
   import rxfc_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chr_valid,
   input logic              rd_en,
   input logic              fc_enable,
   input logic [1:0]        fc_thresh,
   input logic              ovr_clear,
   input logic              rts_n,
   input logic              fifo_full,
   input logic              fifo_empty,
   input logic [CNT_W-1:0]  fill_level,
   input logic              ovr_flag,
   input logic [DATA_W-1:0] rd_data
);

   logic [31:0] free_now;
   assign free_now = 32'(DEPTH) - 32'(fill_level);

   assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(fill_level) <= 32'(DEPTH));

   assert_write_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_valid && !rd_en && !fifo_full) |=> (fill_level == $past(fill_level) + CNT_W'(1)));

   assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && fifo_empty && !chr_valid) |=> ($stable(rd_data) && fifo_empty));

   assert_overrun_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_valid && fifo_full && !rd_en) |=> (ovr_flag && fifo_full));

   assert_overrun_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !ovr_clear) |=> ovr_flag);

   assert_rts_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !fc_enable |=> !rts_n);

   assert_rts_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fc_enable |=> (!(free_now <= 32'(reserve_entries($past(fc_thresh)))) || rts_n));

   assert_rts_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fc_enable |=> (!(free_now >= 32'(reserve_entries($past(fc_thresh))) + 32'd2) || !rts_n));

endmodule

bind rx_flow_fifo rx_flow_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chr_valid  (chr_valid),
   .rd_en      (rd_en),
   .fc_enable  (fc_enable),
   .fc_thresh  (fc_thresh),
   .ovr_clear  (ovr_clear),
   .rts_n      (rts_n),
   .fifo_full  (fifo_full),
   .fifo_empty (fifo_empty),
   .fill_level (fill_level),
   .ovr_flag   (ovr_flag),
   .rd_data    (rd_data)
);

// File: tb/rx_flow_fifo_tb.sv
`timescale 1ns/1ps
module rx_flow_fifo_tb;

   localparam int DEPTH = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chr_valid = 1'b0;
   logic [7:0] chr_data = '0;
   logic       chr_ferr = 1'b0, chr_perr = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       rd_ferr, rd_perr;
   logic       fc_enable = 1'b0;
   logic [1:0] fc_thresh = 2'b00;
   logic       ovr_clear = 1'b0;
   logic       rts_n, fifo_empty, fifo_full, ovr_flag;
   logic [4:0] fill_level;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   rx_flow_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
      .chr_ferr(chr_ferr), .chr_perr(chr_perr), .rd_en(rd_en), .rd_data(rd_data),
      .rd_ferr(rd_ferr), .rd_perr(rd_perr), .fc_enable(fc_enable),
      .fc_thresh(fc_thresh), .ovr_clear(ovr_clear), .rts_n(rts_n),
      .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fill_level(fill_level),
      .ovr_flag(ovr_flag)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Scoreboard: driver pushes every sent item; monitor moves accepted ones.
   logic [9:0] sent_q[$];
   logic [9:0] exp_q[$];

   task automatic cyc(input logic wv, input logic [7:0] d, input logic f, input logic p,
                      input logic rv, input logic clr);
      @(negedge clk);
      chr_valid = wv; chr_data = d; chr_ferr = f; chr_perr = p;
      rd_en = rv; ovr_clear = clr;
      if (wv) sent_q.push_back({f, p, d});
   endtask

   function automatic int rsv(input logic [1:0] s);
      case (s)
         2'b01: return 2;
         2'b10: return 4;
         2'b11: return 8;
         default: return 0;
      endcase
   endfunction

   // Monitor with model of level, overrun and ready-to-send.
   initial begin
      int cnt = 0;
      logic m_ovr = 0, m_rts = 0, prev_rts;
      logic [9:0] last_rd = '0;
      forever begin
         @(posedge clk);
         if (rst_n) begin
            logic wv, rv, en, clr, rfire, acc, rd_empty;
            logic [1:0] th;
            logic [9:0] item;
            int fr;
            wv = chr_valid; rv = rd_en; en = fc_enable; th = fc_thresh; clr = ovr_clear;
            item = '0;
            if (wv) item = sent_q.pop_front();
            rfire = rv && (cnt > 0);
            rd_empty = rv && (cnt == 0);
            acc = wv && (cnt < DEPTH || rfire);
            if (rfire) last_rd = exp_q.pop_front();
            if (acc) exp_q.push_back(item);
            cnt = cnt + (acc ? 1 : 0) - (rfire ? 1 : 0);
            if (wv && !acc) m_ovr = 1; else if (clr) m_ovr = 0;
            prev_rts = m_rts;
            fr = DEPTH - cnt;
            if (!en) m_rts = 0;
            else if (fr <= rsv(th)) m_rts = 1;
            else if (fr >= rsv(th) + 2) m_rts = 0;
            #2;
            if (rfire) begin
               chk("R2 data", rd_data, last_rd[7:0]);
               chk("R2 tags", {rd_ferr, rd_perr}, last_rd[9:8]);
            end
            if (rd_empty) chk("R4 empty read holds", {rd_ferr, rd_perr, rd_data}, last_rd);
            if (en && prev_rts && acc) chk("R9 accepted while stopped", fill_level, cnt);
            else chk("R3 level", fill_level, cnt);
            chk("R3 flags", {fifo_empty, fifo_full}, {cnt == 0, cnt == DEPTH});
            chk("R5 overrun", ovr_flag, m_ovr);
            if (!en) chk("R6 rts idle", rts_n, 0);
            else if (fr <= rsv(th)) chk("R7 rts stop", rts_n, m_rts);
            else chk("R8 rts go/hold", rts_n, m_rts);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset level", fill_level, 0);
      chk("R1 reset flags", {fifo_empty, fifo_full, rts_n, ovr_flag}, 4'b1000);
      chk("R1 reset read", {rd_ferr, rd_perr, rd_data}, 0);
      rst_n = 1'b1;

      // Flow control off: fill past full, clear overrun, drain, read empty.
      fc_thresh = 2'b11;
      for (int i = 0; i < 17; i++) cyc(1, 8'h30 + 8'(i), i[0], i[1], 0, 0);
      cyc(0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 1);
      for (int i = 0; i < 17; i++) cyc(0, 0, 0, 0, 1, 0);
      cyc(0, 0, 0, 0, 1, 0);

      // Each reserve: fill to full plus one, then drain one at a time.
      fc_enable = 1'b1;
      for (int c = 0; c < 4; c++) begin
         fc_thresh = 2'(c);
         for (int i = 0; i < 17; i++) cyc(1, 8'(c * 40 + i) ^ 8'hA5, i[1], i[0], 0, 0);
         cyc(0, 0, 0, 0, 0, 1);
         for (int i = 0; i < 16; i++) begin
            cyc(0, 0, 0, 0, 1, 0);
            cyc(0, 0, 0, 0, 0, 0);
         end
      end

      // Simultaneous write and read: mid level, at full, at empty.
      fc_thresh = 2'b01;
      for (int i = 0; i < 8; i++) cyc(1, 8'h60 + 8'(i), 0, 1, 0, 0);
      for (int i = 0; i < 5; i++) cyc(1, 8'h70 + 8'(i), 1, 0, 1, 0);
      for (int i = 0; i < 8; i++) cyc(1, 8'h80 + 8'(i), 1, 1, 0, 0);
      cyc(1, 8'h99, 0, 0, 1, 0);
      cyc(1, 8'h9A, 1, 1, 0, 0);
      cyc(0, 0, 0, 0, 0, 1);
      for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 1, 0);
      cyc(1, 8'hC3, 1, 0, 1, 0);
      cyc(0, 0, 0, 0, 1, 0);

      // Toggle enable while stopped.
      fc_thresh = 2'b11;
      for (int i = 0; i < 12; i++) cyc(1, 8'hD0 + 8'(i), 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0);
      fc_enable = 1'b0;
      cyc(0, 0, 0, 0, 0, 0);
      fc_enable = 1'b1;
      cyc(0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule